// File: doc/BRIEF.md
# Shared Store-Buffer Storage Arbiter with Global Atomic Lock

This block is the storage side of a small multithreaded system. Every hardware thread owns a FIFO store buffer in front of one shared word array. Writes go into the writer's own buffer, and later drain into the array one entry per cycle. Reads first look in the reader's own buffer for the newest pending write to the same address, and otherwise take the array word. A single global lock gives one thread exclusive use of storage for the span of an atomic read-modify-write. While one thread holds the lock, every other thread is blocked: it can neither read nor drain.

Each thread issues one request at a time on a valid/ready port. The request is a read, a write, a fence, a lock-begin or a lock-end. A request stays on the port until the arbiter accepts it. Acceptance rules per operation:
- A fence is accepted only once the thread's buffer is empty.
- A lock-end is accepted only once the holder's buffer has fully drained. While the lock-end waits, the holder keeps draining.

Contention is resolved by two round-robin arbiters:
- one picks among simultaneous lock-begin requests;
- one picks which unblocked, non-empty buffer owns the single array write port in a cycle.

A lock state machine tracks the lock through three states:
- `LK_FREE`: no holder.
- `LK_HELD`: a holder owns storage.
- `LK_RELEASE`: the holder has asked to end the lock and is still draining.

Its transitions are:
- **grant**: `LK_FREE` to `LK_HELD`, when the lock arbiter picks a thread.
- **quick release**: `LK_HELD` to `LK_FREE`, on a lock-end when the holder's buffer is already empty.
- **start release**: `LK_HELD` to `LK_RELEASE`, on a lock-end while the buffer still has entries.
- **finish release**: `LK_RELEASE` to `LK_FREE`, once the buffer is empty.

Top module: `atomic_store_arbiter`

## Requirements
- R1: A lock-begin (op code 3) is accepted only while no thread holds the lock, and at most one is accepted per cycle. Among simultaneous requesters the winner is the first found searching upward (wrapping) from a pointer. After any grant the pointer becomes the winner plus one, modulo the thread count. The pointer is 0 after reset.
- R2: Output `blocked` bit t is 1 exactly while the lock is held by a thread other than t. It is 0 for all threads after reset.
- R3: A blocked thread has no read accepted and no entry of its buffer written to the shared array.
- R4: A lock-end (op code 4) is accepted only from the holder, and only when the holder's buffer is empty. Until then the holder's buffer keeps draining. Once accepted, the lock is free from the next cycle.
- R5: The lock holder may still read (with forwarding from its own buffer), write into its buffer, and drain.
- R6: At most one buffer entry (the oldest of one buffer) is written to the array per cycle. The candidates are threads that are unblocked and have a non-empty buffer. The choice uses a separate round-robin pointer, with the same rule as R1.
- R7: An accepted read (op code 0) returns its data on `rd_valid`/`rd_data` in the following cycle. The data is the newest pending write to that address in the reader's own buffer if there is one; otherwise it is the array word before that cycle's drain. The array is all zero after reset.
- R8: A write (op code 1) is accepted whenever the writer's buffer is not full, even while the thread is blocked.
- R9: A fence (op code 2) is accepted only when the thread's buffer is empty.
- R10: A request is held on the port and is not lost until `req_ready` is seen with `req_valid`. `req_ready` is meaningful only while `req_valid` is 1. Op codes 5 to 7 are never accepted.
- R11: In the store-then-load pattern across two threads, both loads can return the initial zero when plain writes are used. Both loads never return zero when each write sits inside a lock or is followed by a fence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NTHR | Per-thread request valid |
| req_op | input | 3*NTHR | Per-thread op code, thread t at bits [3t+2:3t] |
| req_addr | input | AW*NTHR | Per-thread word address |
| req_wdata | input | DW*NTHR | Per-thread write data |
| req_ready | output | NTHR | Per-thread request accepted this cycle |
| rd_valid | output | NTHR | Read data valid, one cycle after acceptance |
| rd_data | output | DW*NTHR | Per-thread read data |
| blocked | output | NTHR | Thread is excluded by another thread's lock |

## Verification
The bench runs short per-thread programs under a behavioural reference model compared every cycle.

Three litmus patterns probe the memory ordering:
- Plain store-then-load shows that buffering makes both-zero reachable (R11).
- The same pattern with locked writes, and with fences, shows the drain-before-release and drain-before-fence rules exclude that outcome.

Three further programs probe the lock and the arbiters:
- A lock-holding program with a second thread that writes, then reads while excluded, separates forwarding, blocking and release ordering.
- A two-thread burst followed by fences exposes the drain round-robin through the cycle each fence completes.
- Repeated lock contention exposes the lock round-robin.

// File: rtl/asa_pkg.sv
package asa_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_FENCE  = 3'd2,
        OP_LOCK   = 3'd3,
        OP_UNLOCK = 3'd4
    } asa_op_e;

    typedef enum logic [1:0] {
        LK_FREE    = 2'd0,
        LK_HELD    = 2'd1,
        LK_RELEASE = 2'd2
    } lk_state_e;

endpackage

// File: rtl/asa_rr_arbiter.sv
module asa_rr_arbiter #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_nx;
    logic          found;

    always_comb begin
        grant  = '0;
        found  = 1'b0;
        ptr_nx = ptr;
        for (int k = 0; k < N; k++) begin
            for (int j = 0; j < N; j++) begin
                if (!found && req[j] && (j == ((int'(ptr) + k) % N))) begin
                    grant[j] = 1'b1;
                    found    = 1'b1;
                    ptr_nx   = PW'((j + 1) % N);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nx;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req) == '0)); // R1
endmodule

// File: rtl/asa_store_fifo.sv
module asa_store_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 3,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          empty,
    output logic          full,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] e_addr [DEPTH];
    logic [DW-1:0] e_data [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [PW:0]   cnt;

    assign empty     = (cnt == '0);
    assign full      = (cnt == (PW+1)'(DEPTH));
    assign head_addr = e_addr[rp];
    assign head_data = e_data[rp];

    // newest matching entry wins: scan oldest to newest, keep last hit
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (((PW+1)'(k) < cnt) && (e_addr[rp + PW'(k)] == lk_addr)) begin
                lk_hit  = 1'b1;
                lk_data = e_data[rp + PW'(k)];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            e_addr[wp] <= push_addr;
            e_data[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6
endmodule

// File: rtl/asa_lock_fsm.sv
module asa_lock_fsm
    import asa_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant,
    input  logic [N-1:0] unlock_req,
    input  logic [N-1:0] buf_empty,
    output logic         lock_free,
    output logic [N-1:0] blocked,
    output logic [N-1:0] unlock_ok
);
    lk_state_e    st, st_nx;
    logic [N-1:0] owner, owner_nx;
    logic         own_req, own_empty;

    assign own_req   = |(owner & unlock_req);
    assign own_empty = |(owner & buf_empty);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= LK_FREE;
            owner <= '0;
        end else begin
            st    <= st_nx;
            owner <= owner_nx;
        end
    end

    always_comb begin
        st_nx    = st;
        owner_nx = owner;
        unique case (st)
            LK_FREE: begin
                if (|grant) begin
                    st_nx    = LK_HELD;
                    owner_nx = grant;
                end
            end
            LK_HELD: begin
                if (own_req) begin
                    if (own_empty) begin
                        st_nx    = LK_FREE;
                        owner_nx = '0;
                    end else begin
                        st_nx = LK_RELEASE;
                    end
                end
            end
            LK_RELEASE: begin
                if (own_req && own_empty) begin
                    st_nx    = LK_FREE;
                    owner_nx = '0;
                end
            end
            default: begin
                st_nx    = LK_FREE;
                owner_nx = '0;
            end
        endcase
    end

    always_comb begin
        lock_free = 1'b0;
        blocked   = '0;
        unlock_ok = '0;
        unique case (st)
            LK_FREE: lock_free = 1'b1;
            LK_HELD, LK_RELEASE: begin
                blocked = ~owner;
                if (own_req && own_empty) unlock_ok = owner;
            end
            default: lock_free = 1'b0;
        endcase
    end

    AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (st == LK_FREE)); // R1
    AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != LK_FREE) |-> $onehot(owner)); // R2
    AST_RELEASE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == LK_RELEASE) && !own_empty) |=> (st == LK_RELEASE)); // R4
    AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != LK_FREE) && (unlock_ok == '0)) |=> $stable(owner)); // R2
endmodule

// File: rtl/atomic_store_arbiter.sv
module atomic_store_arbiter
    import asa_pkg::*;
#(
    parameter int NTHR     = 2,
    parameter int SB_DEPTH = 4,
    parameter int AW       = 3,
    parameter int DW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTHR-1:0]    req_valid,
    input  logic [3*NTHR-1:0]  req_op,
    input  logic [AW*NTHR-1:0] req_addr,
    input  logic [DW*NTHR-1:0] req_wdata,
    output logic [NTHR-1:0]    req_ready,
    output logic [NTHR-1:0]    rd_valid,
    output logic [DW*NTHR-1:0] rd_data,
    output logic [NTHR-1:0]    blocked
);
    localparam int MWORDS = 1 << AW;

    asa_op_e         op_t   [NTHR];
    logic [AW-1:0]   addr_t [NTHR];
    logic [DW-1:0]   wd_t   [NTHR];
    logic [AW-1:0]   head_a [NTHR];
    logic [DW-1:0]   head_d [NTHR];
    logic [DW-1:0]   fwd_d  [NTHR];
    logic [NTHR-1:0] fwd_hit, sb_empty, sb_full;
    logic [NTHR-1:0] wr_acc, rd_acc, fence_acc, lock_req, lock_grant;
    logic [NTHR-1:0] unlock_req, unlock_ok, drain_req, pop;
    logic            lock_free;
    logic [DW-1:0]   mem [MWORDS];
    logic            mw_en;
    logic [AW-1:0]   mw_addr;
    logic [DW-1:0]   mw_data;

    asa_lock_fsm #(.N(NTHR)) u_lock (
        .clk(clk), .rst_n(rst_n), .grant(lock_grant), .unlock_req(unlock_req),
        .buf_empty(sb_empty), .lock_free(lock_free), .blocked(blocked),
        .unlock_ok(unlock_ok)
    );

    asa_rr_arbiter #(.N(NTHR)) u_lock_arb (
        .clk(clk), .rst_n(rst_n), .req(lock_req & {NTHR{lock_free}}),
        .grant(lock_grant)
    );

    asa_rr_arbiter #(.N(NTHR)) u_drain_arb (
        .clk(clk), .rst_n(rst_n), .req(drain_req), .grant(pop)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        assign op_t[g]   = asa_op_e'(req_op[g*3 +: 3]);
        assign addr_t[g] = req_addr[g*AW +: AW];
        assign wd_t[g]   = req_wdata[g*DW +: DW];

        assign wr_acc[g]     = req_valid[g] && (op_t[g] == OP_WRITE) && !sb_full[g];
        assign rd_acc[g]     = req_valid[g] && (op_t[g] == OP_READ) && !blocked[g];
        assign fence_acc[g]  = req_valid[g] && (op_t[g] == OP_FENCE) && sb_empty[g];
        assign lock_req[g]   = req_valid[g] && (op_t[g] == OP_LOCK);
        assign unlock_req[g] = req_valid[g] && (op_t[g] == OP_UNLOCK);
        assign drain_req[g]  = !sb_empty[g] && !blocked[g];

        assign req_ready[g] = wr_acc[g] | rd_acc[g] | fence_acc[g]
                            | lock_grant[g] | unlock_ok[g];

        asa_store_fifo #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sb (
            .clk(clk), .rst_n(rst_n),
            .push(wr_acc[g]), .push_addr(addr_t[g]), .push_data(wd_t[g]),
            .pop(pop[g]), .head_addr(head_a[g]), .head_data(head_d[g]),
            .empty(sb_empty[g]), .full(sb_full[g]),
            .lk_addr(addr_t[g]), .lk_hit(fwd_hit[g]), .lk_data(fwd_d[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_valid[g]          <= 1'b0;
                rd_data[g*DW +: DW]  <= '0;
            end else begin
                rd_valid[g] <= rd_acc[g];
                if (rd_acc[g])
                    rd_data[g*DW +: DW] <= fwd_hit[g] ? fwd_d[g] : mem[addr_t[g]];
            end
        end

        AST_BLOCKED_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[g] |-> !pop[g]); // R3
        AST_UNLOCK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
            unlock_ok[g] |-> sb_empty[g]); // R4
        AST_LOCK_THEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            lock_grant[g] |=> (blocked == ~(NTHR'(1) << g))); // R2
    end

    always_comb begin
        mw_en   = 1'b0;
        mw_addr = '0;
        mw_data = '0;
        for (int t = 0; t < NTHR; t++) begin
            if (pop[t]) begin
                mw_en   = 1'b1;
                mw_addr = head_a[t];
                mw_data = head_d[t];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < MWORDS; w++) mem[w] <= '0;
        end else if (mw_en) begin
            mem[mw_addr] <= mw_data;
        end
    end

    AST_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop)); // R6
    AST_ONE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lock_grant)); // R1
    AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc != '0) |=> (rd_valid != '0)); // R7
endmodule

// File: tb/atomic_store_arbiter_bench.sv
module atomic_store_arbiter_bench;
    localparam int NT = 2;
    localparam int DEPTH = 4;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int PMAX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0]    req_valid = '0;
    logic [3*NT-1:0]  req_op = '0;
    logic [AW*NT-1:0] req_addr = '0;
    logic [DW*NT-1:0] req_wdata = '0;
    logic [NT-1:0]    req_ready, rd_valid, blocked;
    logic [DW*NT-1:0] rd_data;

    always #10 clk = ~clk;

    atomic_store_arbiter #(.NTHR(NT), .SB_DEPTH(DEPTH), .AW(AW), .DW(DW)) u_atomic_store_arbiter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .blocked(blocked)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // programs
    int p_op [NT][PMAX];
    int p_ad [NT][PMAX];
    int p_da [NT][PMAX];
    int p_len [NT];
    int pc [NT];
    int rvals [NT][PMAX];
    int rcnt [NT];
    int stall [NT];

    // reference model state
    int m_mem [1<<AW];
    int qa [NT][DEPTH];
    int qd [NT][DEPTH];
    int qn [NT];
    int holder;
    int lk_ptr, dr_ptr;
    bit exp_rdv [NT];
    int exp_rdd [NT];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    function automatic int rr_pick(input bit [NT-1:0] r, input int ptr);
        for (int k = 0; k < NT; k++) begin
            if (r[(ptr + k) % NT]) return (ptr + k) % NT;
        end
        return -1;
    endfunction

    task automatic clear_prog();
        for (int t = 0; t < NT; t++) begin
            p_len[t] = 0; pc[t] = 0; rcnt[t] = 0; stall[t] = 0;
        end
    endtask

    task automatic add(input int t, input int op, input int ad, input int da);
        p_op[t][p_len[t]] = op;
        p_ad[t][p_len[t]] = ad;
        p_da[t][p_len[t]] = da;
        p_len[t]++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = '0;
        repeat (3) @(negedge clk);
        chk(blocked == '0, "R2 reset blocked", int'(blocked), 0);
        chk(rd_valid == '0, "R7 reset rd_valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        for (int w = 0; w < (1<<AW); w++) m_mem[w] = 0;
        for (int t = 0; t < NT; t++) begin qn[t] = 0; exp_rdv[t] = 1'b0; end
        holder = -1; lk_ptr = 0; dr_ptr = 0;
    endtask

    task automatic one_cycle();
        bit [NT-1:0] m_blk, m_rdy, lkr, drr;
        int lw, dw, fv;
        bit hit;
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            chk(rd_valid[t] == exp_rdv[t], "R7 rd_valid", int'(rd_valid[t]), int'(exp_rdv[t]));
            if (exp_rdv[t] && rd_valid[t]) begin
                chk(int'(rd_data[t*DW +: DW]) == exp_rdd[t], "R7 rd_data",
                    int'(rd_data[t*DW +: DW]), exp_rdd[t]);
                rvals[t][rcnt[t]] = int'(rd_data[t*DW +: DW]);
                rcnt[t]++;
            end
        end
        for (int t = 0; t < NT; t++) begin
            if (pc[t] < p_len[t]) begin
                req_valid[t] = 1'b1;
                req_op[t*3 +: 3] = 3'(p_op[t][pc[t]]);
                req_addr[t*AW +: AW] = AW'(p_ad[t][pc[t]]);
                req_wdata[t*DW +: DW] = DW'(p_da[t][pc[t]]);
            end else begin
                req_valid[t] = 1'b0;
            end
        end
        #1;
        lkr = '0; drr = '0;
        for (int t = 0; t < NT; t++) begin
            m_blk[t] = (holder != -1) && (holder != t);
            lkr[t] = req_valid[t] && (p_op[t][pc[t]] == 3) && (holder == -1);
            drr[t] = !m_blk[t] && (qn[t] > 0);
        end
        lw = rr_pick(lkr, lk_ptr);
        dw = rr_pick(drr, dr_ptr);
        for (int t = 0; t < NT; t++) begin
            m_rdy[t] = 1'b0;
            exp_rdv[t] = 1'b0;
            if (req_valid[t]) begin
                case (p_op[t][pc[t]])
                    0: m_rdy[t] = !m_blk[t];
                    1: m_rdy[t] = (qn[t] < DEPTH);
                    2: m_rdy[t] = (qn[t] == 0);
                    3: m_rdy[t] = (lw == t);
                    4: m_rdy[t] = (holder == t) && (qn[t] == 0);
                    default: m_rdy[t] = 1'b0;
                endcase
                chk(req_ready[t] == m_rdy[t], "R10 req_ready", int'(req_ready[t]), int'(m_rdy[t]));
                if (!m_rdy[t]) stall[t]++;
                if (m_rdy[t] && p_op[t][pc[t]] == 0) begin
                    hit = 1'b0; fv = 0;
                    for (int k = 0; k < qn[t]; k++)
                        if (qa[t][k] == p_ad[t][pc[t]]) begin hit = 1'b1; fv = qd[t][k]; end
                    exp_rdv[t] = 1'b1;
                    exp_rdd[t] = hit ? fv : m_mem[p_ad[t][pc[t]]];
                end
            end
        end
        chk(blocked == m_blk, "R2 blocked", int'(blocked), int'(m_blk));
        @(posedge clk);
        if (dw >= 0) begin
            m_mem[qa[dw][0]] = qd[dw][0];
            for (int k = 0; k < DEPTH - 1; k++) begin
                qa[dw][k] = qa[dw][k+1]; qd[dw][k] = qd[dw][k+1];
            end
            qn[dw]--;
            dr_ptr = (dw + 1) % NT;
        end
        if (lw >= 0) begin holder = lw; lk_ptr = (lw + 1) % NT; end
        for (int t = 0; t < NT; t++) begin
            if (m_rdy[t]) begin
                if (p_op[t][pc[t]] == 1) begin
                    qa[t][qn[t]] = p_ad[t][pc[t]]; qd[t][qn[t]] = p_da[t][pc[t]]; qn[t]++;
                end
                if (p_op[t][pc[t]] == 4) holder = -1;
                pc[t]++;
            end
        end
    endtask

    task automatic run_prog();
        bit busy;
        int n;
        do_reset();
        n = 0;
        busy = 1'b1;
        while (busy && n < 200) begin
            one_cycle();
            n++;
            busy = 1'b0;
            for (int t = 0; t < NT; t++) if (pc[t] < p_len[t]) busy = 1'b1;
        end
        chk(!busy, "R10 program completes", int'(busy), 0);
        repeat (10) one_cycle();
    endtask

    initial begin
        // S1: plain store buffering pattern
        clear_prog();
        add(0, 1, 0, 1); add(0, 0, 1, 0);
        add(1, 1, 1, 1); add(1, 0, 0, 0);
        run_prog();
        chk(rvals[0][0] == 0 && rvals[1][0] == 0, "R11 plain both zero",
            rvals[0][0] + rvals[1][0], 0);

        // S2: locked writes
        clear_prog();
        add(0, 3, 0, 0); add(0, 1, 0, 1); add(0, 4, 0, 0); add(0, 0, 1, 0);
        add(1, 3, 0, 0); add(1, 1, 1, 1); add(1, 4, 0, 0); add(1, 0, 0, 0);
        run_prog();
        chk(!(rvals[0][0] == 0 && rvals[1][0] == 0), "R11 locked not both zero",
            rvals[0][0] + rvals[1][0], 1);
        chk(stall[1] > 0, "R1 second locker waits", stall[1], 1);

        // S3: fenced writes
        clear_prog();
        add(0, 1, 0, 1); add(0, 2, 0, 0); add(0, 0, 1, 0);
        add(1, 1, 1, 1); add(1, 2, 0, 0); add(1, 0, 0, 0);
        run_prog();
        chk(!(rvals[0][0] == 0 && rvals[1][0] == 0), "R11 fenced not both zero",
            rvals[0][0] + rvals[1][0], 1);
        chk(stall[0] > 0, "R9 fence waits for drain", stall[0], 1);

        // S4: holder forwarding, blocked thread writes then read stalls
        clear_prog();
        add(0, 3, 0, 0); add(0, 1, 2, 5); add(0, 0, 2, 0); add(0, 1, 3, 6);
        add(0, 0, 3, 0); add(0, 4, 0, 0);
        add(1, 2, 0, 0); add(1, 1, 4, 7); add(1, 0, 4, 0); add(1, 0, 2, 0);
        run_prog();
        chk(rvals[0][0] == 5, "R5 holder forwarding", rvals[0][0], 5);
        chk(rvals[0][1] == 6, "R5 holder second forward", rvals[0][1], 6);
        chk(rvals[1][0] == 7, "R8 write accepted while blocked", rvals[1][0], 7);
        chk(rvals[1][1] == 5, "R4 drained before release", rvals[1][1], 5);
        chk(stall[1] >= 3, "R3 blocked read stalls", stall[1], 3);

        // S5: drain round-robin seen through fence completion
        clear_prog();
        for (int i = 0; i < 3; i++) begin add(0, 1, i, i + 1); add(1, 1, i + 4, i + 9); end
        add(0, 2, 0, 0); add(0, 0, 2, 0);
        add(1, 2, 0, 0); add(1, 0, 6, 0);
        run_prog();
        chk(rvals[0][0] == 3, "R6 drained value in memory", rvals[0][0], 3);
        chk(rvals[1][0] == 11, "R6 drained value in memory", rvals[1][0], 11);

        // S6: repeated lock contention, round-robin lock order
        clear_prog();
        add(0, 3, 0, 0); add(0, 4, 0, 0); add(0, 3, 0, 0); add(0, 4, 0, 0);
        add(1, 3, 0, 0); add(1, 4, 0, 0); add(1, 3, 0, 0); add(1, 4, 0, 0);
        run_prog();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule